// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire SMBus slave that exposes a bank of 8-bit configuration registers to a host. The host reaches the bank through single-byte, two-byte and whole-bank transfers in both directions. The first byte after the address is a command code. Its top bit chooses between indexed access, where the low seven bits give a register offset, and whole-bank access, which always begins at offset 0. A whole-bank write carries a byte count ahead of its data, and a whole-bank read returns the bank size ahead of its data.

SCL and SDA arrive as raw levels. They are resynchronised into the system clock domain and sampled there. The block drives SDA only through an open-drain enable. Two register bytes are read-only: one mirrors a set of strap inputs, and one holds a fixed identification value. One bit in another byte is a sticky event flag. Hardware sets it, and the host clears it by writing a 1. Each accepted data byte gives a one-cycle strobe for its register, so that the frequency and watchdog logic can react to the new value.

Top module: `smb_regfile_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal parameter `SLV_ADDR` (default 7'h69). Bit 0 of the address byte is 1 for a read. For any other address the slave does not acknowledge, and it ignores the bus until the next start condition.
- R2: In the command byte, bit 7 = 1 selects indexed access at offset bits 6:0. Bit 7 = 0 with bits 6:0 = 0 selects a whole-bank transfer. Bit 7 = 0 with any nonzero low bit is not acknowledged, and the rest of the transfer is ignored.
- R3: In an indexed write, successive data bytes are stored at offset, offset+1, and so on. Each byte is acknowledged and is received most significant bit first. A byte cut short by a stop condition is discarded.
- R4: After a repeated start and a read address, an indexed read returns offset, offset+1, and so on, most significant bit first. It goes on until the host answers a byte with NACK.
- R5: In a whole-bank write, the first byte after the command is a count. The count is acknowledged and not stored. The data bytes that follow go to offsets 0, 1, 2, and so on. Only fully received bytes take effect, and any stop after a complete byte is allowed.
- R6: A whole-bank read first returns the register count `NREG` (default 16). It then returns the registers from offset 0 upward.
- R7: Offset 5 reads back the `strap_i` inputs, and offset 8 reads back {`REV_ID`, 4'b1000}. Writes to either offset are acknowledged but change nothing and raise no strobe.
- R8: Bit 2 of offset 9 is set by a `status_set_i` pulse. Writing 1 to it clears it, and writing 0 leaves it unchanged. The other bits of offset 9 are plain read/write.
- R9: Writes to an offset of `NREG` or above are acknowledged and discarded, with no strobe. Reads from such an offset return 8'h00.
- R10: Each stored data byte raises `wr_stb_o[i]` for exactly one cycle, and `cfg_o` byte i shows the new value from that cycle on. At most one strobe is high at a time.
- R11: After reset all writable registers are 0, the strap byte is 0 until it is first sampled, and `sda_oe_o` is low.
- R12: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SMBus clock level |
| sda_i | input | 1 | Raw SMBus data level (wired bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 8 | Strap levels mirrored into offset 5 |
| status_set_i | input | 1 | Event pulse setting the sticky status bit |
| cfg_o | output | NREG*8 | All register bytes, byte i at bits 8i+7:8i |
| wr_stb_o | output | NREG | Per-register write strobe |

## Verification
The bench goes after the following cases:
- A stop in the middle of a byte. A design that commits partially shifted data would corrupt the register.
- A whole-bank write stopped after two data bytes. Here a design that trusts the count would write stale data.
- A foreign address followed by data. A design that keeps listening would write the register.
- A whole-bank command with a stray low bit. A design that decodes loosely would accept it.
- Writes to both read-only bytes, to out-of-range offsets, and writing 0 or 1 to the sticky flag. A wrong read-only or clear-on-one decode shows up as a changed value or an unwanted strobe.
- A two-byte read that runs past the last register, which must return zero.
- Random indexed traffic, checked against a model of the bank.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } eng_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_COUNT,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        eng_state_e        st;
        rx_kind_e          kind;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              oe;
        logic              rd;
        logic              blk;
        logic              cnt_pend;
        logic              mack;
        logic [PTR_W-1:0]  ptr;
        logic              wr_en;
        logic [PTR_W-1:0]  wr_idx;
        logic [BYTE_W-1:0] wr_data;
    } eng_t;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[LAST];
        d.sda_prev = q.sda_pipe[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl_pipe <= '1;
            q.sda_pipe <= '1;
            q.scl_prev <= 1'b1;
            q.sda_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_o   = q.scl_pipe[LAST];
    assign sda_o   = q.sda_pipe[LAST];
    assign start_o = scl_o & q.scl_prev & q.sda_prev & ~sda_o;
    assign stop_o  = scl_o & q.scl_prev & ~q.sda_prev & sda_o;
    assign rise_o  = scl_o & ~q.scl_prev;
    assign fall_o  = ~scl_o & q.scl_prev;

endmodule

// File: rtl/smb_engine.sv
module smb_engine
    import smb_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h69,
    parameter int         NREG     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [PTR_W-1:0]  rd_idx_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sda_oe_o
);

    localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NREG);
    localparam logic [3:0]        BITS       = 4'(BYTE_W);

    eng_t q, d;
    logic [PTR_W-1:0]  ptr_inc;
    logic [BYTE_W-1:0] tx_byte;

    assign ptr_inc = (q.ptr == '1) ? q.ptr : q.ptr + PTR_W'(1);
    assign tx_byte = q.cnt_pend ? COUNT_BYTE : rd_data_i;

    always_comb begin
        d = q;
        d.wr_en = 1'b0;
        if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_i) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.mack = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (rise_i && q.cnt != BITS) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_i && q.cnt == BITS) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        d.oe  = 1'b1;
                        unique case (q.kind)
                            K_ADDR: begin
                                if (q.sh[7:1] == SLV_ADDR) begin
                                    d.rd       = q.sh[0];
                                    d.cnt_pend = q.sh[0] & q.blk;
                                end else begin
                                    d.st = ST_SKIP;
                                    d.oe = 1'b0;
                                end
                            end
                            K_CMD: begin
                                if (q.sh[7]) begin
                                    d.blk = 1'b0;
                                    d.ptr = {1'b0, q.sh[6:0]};
                                end else if (q.sh[6:0] == 7'd0) begin
                                    d.blk = 1'b1;
                                    d.ptr = '0;
                                end else begin
                                    d.st = ST_SKIP;
                                    d.oe = 1'b0;
                                end
                            end
                            K_COUNT: begin
                                d.ptr = '0;
                            end
                            K_DATA: begin
                                d.wr_en   = 1'b1;
                                d.wr_idx  = q.ptr;
                                d.wr_data = q.sh;
                                d.ptr     = ptr_inc;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall_i) begin
                        d.oe = 1'b0;
                        if (q.kind == K_ADDR && q.rd) begin
                            d.st       = ST_TX;
                            d.sh       = tx_byte;
                            d.oe       = ~tx_byte[BYTE_W-1];
                            d.cnt      = 4'd1;
                            d.cnt_pend = 1'b0;
                            if (!q.cnt_pend) d.ptr = ptr_inc;
                        end else begin
                            d.st  = ST_RX;
                            d.cnt = '0;
                            unique case (q.kind)
                                K_ADDR:  d.kind = K_CMD;
                                K_CMD:   d.kind = q.blk ? K_COUNT : K_DATA;
                                K_COUNT: d.kind = K_DATA;
                                K_DATA:  d.kind = K_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (fall_i) begin
                        if (q.cnt == BITS) begin
                            d.oe   = 1'b0;
                            d.st   = ST_MACK;
                            d.mack = 1'b0;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_i) begin
                        if (sda_i) d.st = ST_SKIP;
                        else       d.mack = 1'b1;
                    end else if (fall_i && q.mack) begin
                        d.st       = ST_TX;
                        d.sh       = tx_byte;
                        d.oe       = ~tx_byte[BYTE_W-1];
                        d.cnt      = 4'd1;
                        d.mack     = 1'b0;
                        d.cnt_pend = 1'b0;
                        if (!q.cnt_pend) d.ptr = ptr_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.kind     <= K_ADDR;
            q.cnt      <= '0;
            q.sh       <= '0;
            q.oe       <= 1'b0;
            q.rd       <= 1'b0;
            q.blk      <= 1'b0;
            q.cnt_pend <= 1'b0;
            q.mack     <= 1'b0;
            q.ptr      <= '0;
            q.wr_en    <= 1'b0;
            q.wr_idx   <= '0;
            q.wr_data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_idx_o  = q.ptr;
    assign wr_en_o   = q.wr_en;
    assign wr_idx_o  = q.wr_idx;
    assign wr_data_o = q.wr_data;
    assign sda_oe_o  = q.oe;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter int         NREG      = 16,
    parameter int         STRAP_IDX = 5,
    parameter int         VID_IDX   = 8,
    parameter int         STAT_IDX  = 9,
    parameter int         STAT_BIT  = 2,
    parameter logic [3:0] REV_ID    = 4'h3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [PTR_W-1:0]     wr_idx_i,
    input  logic [BYTE_W-1:0]    wr_data_i,
    input  logic [PTR_W-1:0]     rd_idx_i,
    output logic [BYTE_W-1:0]    rd_data_o,
    input  logic [BYTE_W-1:0]    strap_i,
    input  logic                 status_set_i,
    output logic [NREG*BYTE_W-1:0] cfg_o,
    output logic [NREG-1:0]      wr_stb_o
);

    localparam logic [BYTE_W-1:0] VID_BYTE = {REV_ID, 4'b1000};

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] regs;
        logic [NREG-1:0]             stb;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        d.stb = '0;
        for (int i = 0; i < NREG; i++) begin
            if (i == STRAP_IDX) begin
                d.regs[i] = strap_i;
            end else if (i == VID_IDX) begin
                d.regs[i] = VID_BYTE;
            end else if (wr_en_i && wr_idx_i == PTR_W'(i)) begin
                d.regs[i] = wr_data_i;
                d.stb[i]  = 1'b1;
                if (i == STAT_IDX)
                    d.regs[i][STAT_BIT] = q.regs[i][STAT_BIT] & ~wr_data_i[STAT_BIT];
            end
            if (i == STAT_IDX && status_set_i)
                d.regs[i][STAT_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.regs          <= '0;
            q.regs[VID_IDX] <= VID_BYTE;
            q.stb           <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx_i == PTR_W'(i)) rd_data_o = q.regs[i];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_cfg
        assign cfg_o[g*BYTE_W +: BYTE_W] = q.regs[g];
    end

    assign wr_stb_o = q.stb;

endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h69,
    parameter int         NREG        = 16,
    parameter int         SYNC_STAGES = 2,
    parameter int         STRAP_IDX   = 5,
    parameter int         VID_IDX     = 8,
    parameter int         STAT_IDX    = 9,
    parameter int         STAT_BIT    = 2,
    parameter logic [3:0] REV_ID      = 4'h3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [7:0]             strap_i,
    input  logic                   status_set_i,
    output logic [NREG*8-1:0]      cfg_o,
    output logic [NREG-1:0]        wr_stb_o
);

    logic              scl_sync, sda_sync;
    logic              start_p, stop_p, rise_p, fall_p;
    logic [PTR_W-1:0]  rd_idx, wr_idx;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic              wr_en;

    smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_o   (scl_sync),
        .sda_o   (sda_sync),
        .start_o (start_p),
        .stop_o  (stop_p),
        .rise_o  (rise_p),
        .fall_o  (fall_p)
    );

    smb_engine #(.SLV_ADDR(SLV_ADDR), .NREG(NREG)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_i     (sda_sync),
        .start_i   (start_p),
        .stop_i    (stop_p),
        .rise_i    (rise_p),
        .fall_i    (fall_p),
        .rd_data_i (rd_data),
        .rd_idx_o  (rd_idx),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    smb_regbank #(
        .NREG(NREG), .STRAP_IDX(STRAP_IDX), .VID_IDX(VID_IDX),
        .STAT_IDX(STAT_IDX), .STAT_BIT(STAT_BIT), .REV_ID(REV_ID)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_idx_i     (wr_idx),
        .wr_data_i    (wr_data),
        .rd_idx_i     (rd_idx),
        .rd_data_o    (rd_data),
        .strap_i      (strap_i),
        .status_set_i (status_set_i),
        .cfg_o        (cfg_o),
        .wr_stb_o     (wr_stb_o)
    );

endmodule

// File: rtl/smb_regfile_chk.sv
module smb_regfile_chk #(
    parameter int NREG      = 16,
    parameter int STRAP_IDX = 5,
    parameter int VID_IDX   = 8,
    parameter int STAT_IDX  = 9,
    parameter int STAT_BIT  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_sync,
    input logic              sda_oe_o,
    input logic              status_set_i,
    input logic [NREG-1:0]   wr_stb_o,
    input logic [NREG*8-1:0] cfg_o
);

    // R12
    oe_hold_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_sync);

    // R10
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o));

    // R7
    ro_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_o[STRAP_IDX] && !wr_stb_o[VID_IDX]);

    // R8
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_set_i |=> cfg_o[STAT_IDX*8 + STAT_BIT]);

    // R10
    stb_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb_o) |-> !scl_sync);

endmodule

bind smb_regfile_slave smb_regfile_chk #(
    .NREG(NREG), .STRAP_IDX(STRAP_IDX), .VID_IDX(VID_IDX),
    .STAT_IDX(STAT_IDX), .STAT_BIT(STAT_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_sync     (scl_sync),
    .sda_oe_o     (sda_oe_o),
    .status_set_i (status_set_i),
    .wr_stb_o     (wr_stb_o),
    .cfg_o        (cfg_o)
);

// File: tb/smb_regfile_slave_test.sv
module smb_regfile_slave_test;

    localparam logic [6:0] ADDR   = 7'h69;
    localparam int         NREG   = 16;
    localparam int         STRAPI = 5;
    localparam int         VIDI   = 8;
    localparam int         STATI  = 9;
    localparam int         STATB  = 2;
    localparam logic [3:0] REV    = 4'h3;
    localparam int         Q      = 5;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] strap = 8'hA5;
    logic stat_set = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] cfg;
    logic [NREG-1:0] stb;
    wire sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    smb_regfile_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .status_set_i(stat_set),
        .cfg_o(cfg), .wr_stb_o(stb)
    );

    int checks = 0, fails = 0, viol = 0;
    bit done = 0;
    int stb_cnt [NREG];
    logic [7:0] model [NREG];
    logic [7:0] tx_buf [32];
    logic [7:0] rx_buf [32];
    logic scl_prev = 1'b1, oe_prev = 1'b0;

    initial for (int i = 0; i < NREG; i++) stb_cnt[i] = 0;

    always @(negedge clk) begin
        for (int i = 0; i < NREG; i++) if (rst_n && stb[i]) stb_cnt[i]++;
        if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    function automatic int stb_total();
        int s = 0;
        for (int i = 0; i < NREG; i++) s += stb_cnt[i];
        return s;
    endfunction

    function automatic logic [7:0] exp_rd(int off);
        if (off >= NREG) return 8'h00;
        if (off == STRAPI) return strap;
        if (off == VIDI) return {REV, 4'b1000};
        return model[off];
    endfunction

    function automatic void model_wr(int off, logic [7:0] v);
        if (off >= NREG || off == STRAPI || off == VIDI) return;
        if (off == STATI) begin
            logic keep;
            keep = model[off][STATB] & ~v[STATB];
            model[off] = v;
            model[off][STATB] = keep;
        end else begin
            model[off] = v;
        end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic v);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); v = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic v;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(v);
        ack = ~v;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit last);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        put_bit(last);
    endtask

    // start, address+W, command, n bytes from tx_buf, stop
    task automatic do_write(input logic [7:0] cmd, input int n, output bit all_ack);
        bit a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); all_ack = a;
        send_byte(cmd, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(tx_buf[i], a); all_ack &= a;
        end
        bus_stop();
    endtask

    // start, address+W, command, repeated start, address+R, n bytes into rx_buf, stop
    task automatic do_read(input logic [7:0] cmd, input int n, output bit all_ack);
        bit a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); all_ack = a;
        send_byte(cmd, a); all_ack &= a;
        bus_start();
        send_byte({ADDR, 1'b1}, a); all_ack &= a;
        for (int i = 0; i < n; i++) recv_byte(rx_buf[i], (i == n - 1));
        bus_stop();
    endtask

    task automatic pulse_status();
        @(negedge clk); stat_set = 1'b1; @(negedge clk); stat_set = 1'b0; wq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ack, a;
        int tot, off, op;
        logic [7:0] v0, v1;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;

        repeat (10) @(negedge clk);
        // R11 reset state
        chk("R11 sda_oe after reset", sda_oe, 0);
        for (int i = 0; i < NREG; i++)
            if (i != STRAPI && i != VIDI) chk("R11 reset register value", cfg[i*8 +: 8], 0);
        rst_n = 1'b1;
        wq();

        // R3 / R10 directed byte write, MSB first
        tx_buf[0] = 8'h5A;
        do_write(8'h83, 1, ack);
        model_wr(3, 8'h5A);
        chk("R3 byte write acks", ack, 1);
        chk("R10 cfg byte 3", cfg[3*8 +: 8], 8'h5A);
        chk("R10 strobe count byte 3", stb_cnt[3], 1);
        // R4 byte read
        do_read(8'h83, 1, ack);
        chk("R4 byte read acks", ack, 1);
        chk("R4 byte read value", rx_buf[0], 8'h5A);

        // R3 / R4 word
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22;
        do_write(8'h8A, 2, ack);
        model_wr(10, 8'h11); model_wr(11, 8'h22);
        do_read(8'h8A, 2, ack);
        chk("R4 word read low", rx_buf[0], 8'h11);
        chk("R4 word read high", rx_buf[1], 8'h22);

        // R5 whole-bank write of 4 bytes
        tx_buf[0] = 8'd4;
        for (int i = 0; i < 4; i++) tx_buf[i+1] = 8'hC0 + 8'(i);
        do_write(8'h00, 5, ack);
        for (int i = 0; i < 4; i++) model_wr(i, 8'hC0 + 8'(i));
        chk("R5 block write acks", ack, 1);
        for (int i = 0; i < 4; i++) chk("R5 block write data", cfg[i*8 +: 8], model[i]);

        // R6 whole-bank read
        do_read(8'h00, NREG + 1, ack);
        chk("R6 block read count byte", rx_buf[0], NREG);
        for (int i = 0; i < NREG; i++) chk("R6 block read data", rx_buf[i+1], exp_rd(i));

        // R5 stop after two data bytes of a count of six
        tx_buf[0] = 8'd6; tx_buf[1] = 8'h71; tx_buf[2] = 8'h72;
        do_write(8'h00, 3, ack);
        model_wr(0, 8'h71); model_wr(1, 8'h72);
        chk("R5 partial block byte 1", cfg[1*8 +: 8], 8'h72);
        chk("R5 partial block byte 2 kept", cfg[2*8 +: 8], model[2]);

        // R3 stop inside a byte discards it
        tot = stb_total();
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h80, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk("R3 truncated byte no strobe", stb_total(), tot);
        chk("R3 truncated byte value", cfg[7:0], model[0]);

        // R1 foreign address
        tot = stb_total();
        bus_start();
        send_byte({ADDR ^ 7'h01, 1'b0}, a);
        chk("R1 foreign address nack", a, 0);
        send_byte(8'h81, a);
        send_byte(8'hEE, a);
        bus_stop();
        chk("R1 foreign address no strobe", stb_total(), tot);
        chk("R1 foreign address no change", cfg[1*8 +: 8], model[1]);

        // R2 bad whole-bank command
        tot = stb_total();
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        chk("R2 address ack", a, 1);
        send_byte(8'h05, a);
        chk("R2 bad command nack", a, 0);
        send_byte(8'h99, a);
        bus_stop();
        chk("R2 bad command no strobe", stb_total(), tot);

        // R7 read-only bytes
        tx_buf[0] = 8'hFF;
        do_write(8'h80 | 8'(STRAPI), 1, ack);
        chk("R7 strap write ack", ack, 1);
        tx_buf[0] = 8'h00;
        do_write(8'h80 | 8'(VIDI), 1, ack);
        chk("R7 vendor write ack", ack, 1);
        do_read(8'h80 | 8'(STRAPI), 1, ack);
        chk("R7 strap readback", rx_buf[0], strap);
        do_read(8'h80 | 8'(VIDI), 1, ack);
        chk("R7 vendor readback", rx_buf[0], {REV, 4'b1000});
        chk("R7 no strobe strap", stb_cnt[STRAPI], 0);
        chk("R7 no strobe vendor", stb_cnt[VIDI], 0);

        // R8 sticky status bit
        pulse_status();
        model[STATI][STATB] = 1'b1;
        do_read(8'h80 | 8'(STATI), 1, ack);
        chk("R8 status set by event", rx_buf[0], 8'h04);
        tx_buf[0] = 8'h00;
        do_write(8'h80 | 8'(STATI), 1, ack);
        model_wr(STATI, 8'h00);
        do_read(8'h80 | 8'(STATI), 1, ack);
        chk("R8 write 0 keeps status", rx_buf[0], 8'h04);
        tx_buf[0] = 8'h85;
        do_write(8'h80 | 8'(STATI), 1, ack);
        model_wr(STATI, 8'h85);
        do_read(8'h80 | 8'(STATI), 1, ack);
        chk("R8 write 1 clears status", rx_buf[0], 8'h81);

        // R9 out of range
        tot = stb_total();
        tx_buf[0] = 8'h77;
        do_write(8'hC0, 1, ack);
        chk("R9 out of range write ack", ack, 1);
        chk("R9 out of range no strobe", stb_total(), tot);
        do_read(8'hC0, 1, ack);
        chk("R9 out of range read", rx_buf[0], 8'h00);
        do_read(8'h80 | 8'(NREG - 1), 2, ack);
        chk("R4 word read last register", rx_buf[0], exp_rd(NREG - 1));
        chk("R9 word read past end", rx_buf[1], 8'h00);

        // R3 / R4 random indexed traffic
        for (int it = 0; it < 24; it++) begin
            op  = $urandom_range(0, 3);
            off = $urandom_range(0, NREG + 3);
            v0  = 8'($urandom); v1 = 8'($urandom);
            tx_buf[0] = v0; tx_buf[1] = v1;
            case (op)
                0: begin do_write(8'h80 | 8'(off), 1, ack); model_wr(off, v0);
                         chk("R3 random byte write ack", ack, 1); end
                1: begin do_write(8'h80 | 8'(off), 2, ack); model_wr(off, v0); model_wr(off + 1, v1);
                         chk("R3 random word write ack", ack, 1); end
                2: begin do_read(8'h80 | 8'(off), 1, ack);
                         chk("R4 random byte read", rx_buf[0], exp_rd(off)); end
                default: begin do_read(8'h80 | 8'(off), 2, ack);
                         chk("R4 random word read low", rx_buf[0], exp_rd(off));
                         chk("R4 random word read high", rx_buf[1], exp_rd(off + 1)); end
            endcase
        end
        for (int i = 0; i < NREG; i++)
            if (i != STRAPI && i != VIDI) chk("R10 final cfg image", cfg[i*8 +: 8], model[i]);

        chk("R12 sda drive changed with SCL high", viol, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule